// File: doc/BRIEF.md
# Transfer Byte-Count Controller for a Serial Bus Master

This block decides how many data bytes a two-wire serial bus master moves in one transfer, and tells the master when to finish with a STOP. Software programs a 16-bit length value through a simple register port. When the byte engine signals the start of a transfer, the block copies that value into a hidden 17-bit countdown. Each byte-completion pulse from the byte engine, whether it sent or received the byte, takes one off the countdown. When the countdown runs out and the master was told to end with STOP, the block emits a one-cycle STOP request.

A programmed length of zero stands for 65536 bytes. The programmed value is never altered by counting, so it reads back as written and serves again at the next start. A last-byte flag is raised while exactly one byte remains, so a receiving byte engine can answer the final byte with a NACK. In repeat mode the length is not used: bytes flow with no countdown and no automatic STOP until software steps in with a new start.

The sequencer has four states. IDLE holds after reset. COUNT runs the countdown. FREE is the repeat-mode state, where counting is bypassed. DONE is entered once the count is spent. The transitions are GO_COUNT (start with repeat low, from any state), GO_FREE (start with repeat high, from any state), BYPASS (COUNT to FREE when repeat mode rises during counting) and FINISH (COUNT to DONE on the byte that empties the count). A start received in COUNT takes the GO_COUNT or GO_FREE edge, so it restarts the transfer.

Top module: `xfer_count_ctl`

## Requirements
- R1: A synchronous active-high reset clears the programmed length to 0, abandons any countdown (state IDLE), and holds `stop_pulse` and `last_byte` low.
- R2: A cycle with `reg_we` high stores `reg_wdata`. `reg_rdata` always shows the last stored value, and counting never changes it.
- R3: A `xfer_start` pulse with `repeat_mode` low loads the programmed length L (1 to 65535) into the countdown. Each later `byte_done` pulse takes one byte off the countdown, so the transfer ends on the L-th pulse.
- R4: A programmed length of 0 makes the transfer 65536 bytes long.
- R5: If `stop_req` is high on the `byte_done` that empties the countdown, `stop_pulse` is high for exactly one cycle, the cycle after that pulse, and at no other time.
- R6: If `stop_req` is low on the `byte_done` that empties the countdown, no `stop_pulse` is produced, and the transfer still counts as complete.
- R7: If `repeat_mode` is high at `xfer_start`, or rises while a countdown is running, counting stops. No `stop_pulse` and no `last_byte` follow until the next start with `repeat_mode` low.
- R8: `last_byte` is high exactly while a countdown is running and one byte is left.
- R9: A write to the length register during a transfer has no effect on the running countdown. The new value is used at the next `xfer_start`.
- R10: `byte_done` pulses that arrive after the count is spent produce neither `stop_pulse` nor `last_byte`.
- R11: An `xfer_start` during a running countdown restarts it from the programmed length. In a cycle with both `xfer_start` and `byte_done` high, the start wins and the byte is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Write strobe for the length register |
| reg_wdata | input | 16 | Length value to store |
| reg_rdata | output | 16 | Stored length value |
| xfer_start | input | 1 | Start-of-transfer pulse from the byte engine |
| byte_done | input | 1 | One-cycle pulse for each completed data byte |
| repeat_mode | input | 1 | High to bypass counting |
| stop_req | input | 1 | High when the master should end with STOP |
| stop_pulse | output | 1 | One-cycle STOP request after the final byte |
| last_byte | output | 1 | High while one byte remains in the countdown |

## Verification
The bench sweeps lengths 1 to 24 against several gap patterns between byte pulses, and checks every cycle that `last_byte` and `stop_pulse` land on the byte predicted by the arithmetic. A design off by one would flag the last byte early, or issue STOP a byte late. The zero-length case runs a full 65536-byte countdown. A design that treated zero as zero bytes, or wrapped the counter, would stop at once or never. Further cases cover writes during a transfer, extra pulses after completion, repeat mode at start and in mid-count, start-versus-byte collisions and reset in mid-transfer. A design that let a write reach the live counter, or that wrapped below zero, would issue a STOP at the wrong time or a second STOP.

// File: rtl/xcc_pkg.sv
package xcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FREE  = 2'd2,
        ST_DONE  = 2'd3
    } xcc_state_t;
endpackage

// File: rtl/xcc_count_reg.sv
module xcc_count_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (we) begin
            value <= wdata;
        end
    end
endmodule

// File: rtl/xcc_downcount.sv
module xcc_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] prog,
    output logic             at_one
);
    localparam int CTR_W = CNT_W + 1;
    localparam logic [CTR_W-1:0] FULL_RANGE = CTR_W'(1) << CNT_W;

    logic [CTR_W-1:0] ctr;
    logic [CTR_W-1:0] load_val;

    // A programmed zero selects the full range of the length field.
    always_comb begin
        if (prog == '0) begin
            load_val = FULL_RANGE;
        end else begin
            load_val = {1'b0, prog};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr <= '0;
        end else if (load) begin
            ctr <= load_val;
        end else if (dec && (ctr != '0)) begin
            ctr <= ctr - CTR_W'(1);
        end
    end

    assign at_one = (ctr == CTR_W'(1));
endmodule

// File: rtl/xcc_seq.sv
module xcc_seq
    import xcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic xfer_start,
    input  logic byte_done,
    input  logic repeat_mode,
    input  logic stop_req,
    input  logic at_one,
    output logic load,
    output logic dec,
    output logic stop_pulse,
    output logic last_byte
);
    xcc_state_t state, state_nxt;
    logic       counted_byte;
    logic       final_byte;

    assign counted_byte = (state == ST_COUNT) && byte_done && !xfer_start && !repeat_mode;
    assign final_byte   = counted_byte && at_one;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE, ST_FREE, ST_DONE: begin
                if (xfer_start) begin
                    state_nxt = repeat_mode ? ST_FREE : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (xfer_start) begin
                    state_nxt = repeat_mode ? ST_FREE : ST_COUNT;
                end else if (repeat_mode) begin
                    state_nxt = ST_FREE;
                end else if (final_byte) begin
                    state_nxt = ST_DONE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_pulse <= 1'b0;
        end else begin
            stop_pulse <= final_byte && stop_req;
        end
    end

    always_comb begin
        load      = xfer_start && !repeat_mode;
        dec       = counted_byte;
        last_byte = (state == ST_COUNT) && at_one;
    end
endmodule

// File: rtl/xfer_count_ctl.sv
module xfer_count_ctl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             xfer_start,
    input  logic             byte_done,
    input  logic             repeat_mode,
    input  logic             stop_req,
    output logic             stop_pulse,
    output logic             last_byte
);
    logic [CNT_W-1:0] prog_len;
    logic             ld;
    logic             dn;
    logic             one_left;

    xcc_count_reg #(.CNT_W(CNT_W)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .value (prog_len)
    );

    xcc_downcount #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .load   (ld),
        .dec    (dn),
        .prog   (prog_len),
        .at_one (one_left)
    );

    xcc_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .xfer_start  (xfer_start),
        .byte_done   (byte_done),
        .repeat_mode (repeat_mode),
        .stop_req    (stop_req),
        .at_one      (one_left),
        .load        (ld),
        .dec         (dn),
        .stop_pulse  (stop_pulse),
        .last_byte   (last_byte)
    );

    assign reg_rdata = prog_len;
endmodule

// File: rtl/xfer_count_ctl_chk.sv
module xfer_count_ctl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [CNT_W-1:0] reg_wdata,
    input logic [CNT_W-1:0] reg_rdata,
    input logic             xfer_start,
    input logic             byte_done,
    input logic             repeat_mode,
    input logic             stop_req,
    input logic             stop_pulse,
    input logic             last_byte
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!stop_pulse && !last_byte && reg_rdata == '0));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_we) && !$past(rst)) |-> reg_rdata == $past(reg_wdata));

    p_hold_value_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(reg_we) && !$past(rst)) |-> $stable(reg_rdata));

    p_single_stop_r5: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !stop_pulse);

    p_stop_cause_r5: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |-> ($past(byte_done) && $past(stop_req)));

    p_repeat_no_stop_r7: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |-> !$past(repeat_mode));

    p_last_not_stop_r8: assert property (@(posedge clk) disable iff (rst)
        last_byte |-> !stop_pulse);

    p_start_wins_r11: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !stop_pulse);
endmodule

bind xfer_count_ctl xfer_count_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .xfer_start  (xfer_start),
    .byte_done   (byte_done),
    .repeat_mode (repeat_mode),
    .stop_req    (stop_req),
    .stop_pulse  (stop_pulse),
    .last_byte   (last_byte)
);

// File: tb/xfer_count_ctl_tb.sv
module xfer_count_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        xfer_start = 1'b0;
    logic        byte_done = 1'b0;
    logic        repeat_mode = 1'b0;
    logic        stop_req = 1'b0;
    logic        stop_pulse;
    logic        last_byte;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_count_ctl u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .xfer_start(xfer_start), .byte_done(byte_done),
        .repeat_mode(repeat_mode), .stop_req(stop_req),
        .stop_pulse(stop_pulse), .last_byte(last_byte)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input bit exp_stop, input bit exp_last);
        chk({tag, " stop_pulse"}, {15'd0, stop_pulse}, {15'd0, exp_stop});
        chk({tag, " last_byte"}, {15'd0, last_byte}, {15'd0, exp_last});
    endtask

    task automatic write_len(input logic [15:0] v);
        reg_we = 1'b1; reg_wdata = v; step(); reg_we = 1'b0;
    endtask

    task automatic start_xfer(input bit rep);
        repeat_mode = rep; xfer_start = 1'b1; step(); xfer_start = 1'b0;
    endtask

    // Sends n bytes of an already started countdown of length eff,
    // with gap idle cycles after each byte, checking every cycle.
    task automatic run_bytes(input string tag, input int eff, input int n,
                             input int gap, input bit sreq);
        for (int k = 1; k <= n; k++) begin
            stop_req = sreq; byte_done = 1'b1; step(); byte_done = 1'b0;
            chk_out(tag, (k == eff) && sreq, (eff - k) == 1);
            for (int g = 0; g < gap; g++) begin
                step();
                chk_out(tag, 1'b0, (eff - k) == 1);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        // R1: state after reset
        chk("R1 reset rdata", reg_rdata, 16'h0);
        chk_out("R1 reset", 1'b0, 1'b0);

        // R2: write and read back
        write_len(16'hA5C3);
        chk("R2 readback", reg_rdata, 16'hA5C3);
        step();
        chk("R2 hold", reg_rdata, 16'hA5C3);

        // R3 R5 R8: sweep of lengths and gap patterns
        for (int gap = 0; gap < 3; gap++) begin
            for (int n = 1; n <= 24; n++) begin
                write_len(16'(n));
                start_xfer(1'b0);
                chk_out("R8 after start", 1'b0, n == 1);
                run_bytes("R3 R5 sweep", n, n, gap, 1'b1);
                chk("R2 untouched by count", reg_rdata, 16'(n));
            end
        end

        // R6: STOP not requested
        write_len(16'd4);
        start_xfer(1'b0);
        run_bytes("R6 no stop", 4, 4, 1, 1'b0);

        // R10: extra bytes after completion
        write_len(16'd2);
        start_xfer(1'b0);
        run_bytes("R10 base", 2, 2, 0, 1'b1);
        run_bytes("R10 extra", -100, 5, 0, 1'b1);

        // R9: mid-transfer write is ignored until next start
        write_len(16'd5);
        start_xfer(1'b0);
        run_bytes("R9 first part", 5, 2, 0, 1'b1);
        write_len(16'd2);
        chk("R9 readback new", reg_rdata, 16'd2);
        run_bytes("R9 second part", 3, 3, 0, 1'b1);
        start_xfer(1'b0);
        run_bytes("R9 next start", 2, 2, 0, 1'b1);

        // R7: repeat mode at start
        write_len(16'd3);
        start_xfer(1'b1);
        run_bytes("R7 repeat start", -100, 40, 0, 1'b1);
        // R7: repeat mode rising mid-count
        start_xfer(1'b0);
        run_bytes("R7 pre", 3, 1, 0, 1'b1);
        repeat_mode = 1'b1; step();
        run_bytes("R7 bypass", -100, 10, 0, 1'b1);
        repeat_mode = 1'b0;
        run_bytes("R7 stays free", -100, 10, 0, 1'b1);

        // R11: restart mid-count, and start beating a byte in the same cycle
        write_len(16'd3);
        start_xfer(1'b0);
        run_bytes("R11 pre", 3, 2, 0, 1'b1);
        stop_req = 1'b1; byte_done = 1'b1; xfer_start = 1'b1; step();
        byte_done = 1'b0; xfer_start = 1'b0;
        chk_out("R11 collision", 1'b0, 1'b0);
        run_bytes("R11 restarted", 3, 3, 0, 1'b1);

        // R1: reset in mid-transfer
        write_len(16'd2);
        start_xfer(1'b0);
        run_bytes("R1 pre", 2, 1, 0, 1'b1);
        rst = 1'b1; step(); rst = 1'b0;
        chk("R1 mid reset rdata", reg_rdata, 16'h0);
        chk_out("R1 mid reset", 1'b0, 1'b0);
        run_bytes("R1 no count after reset", -100, 3, 0, 1'b1);

        // R4: zero means 65536 bytes
        write_len(16'd0);
        start_xfer(1'b0);
        chk_out("R4 after start", 1'b0, 1'b0);
        run_bytes("R4 full range", 65536, 65536, 0, 1'b1);
        step();
        chk_out("R4 after stop", 1'b0, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule